// File: doc/BRIEF.md
# Grouped Interrupt Controller with Polarity and Trigger Control

This block gathers 64 interrupt inputs organised as four groups of 16 and reduces them to one interrupt line for the processor. The four groups are local bus sources (group 0), LPC/serial interrupt sources (group 1), PCI and on-chip device sources (group 2) and non-maskable-class sources (group 3). Each group has its own 16-bit block register, detection-mode register, polarity register and request register. Every input can therefore be sensed as a level or as an edge, be active-high or active-low, and be blocked on its own.

The controller reports which groups hold an unblocked request in a 4-bit summary. It raises the processor line when any group does. It also gives a 6-bit vector that names the source to serve next. Software reaches the registers through a simple single-cycle port: a write strobe with address and data, and a combinational read. Latched edge requests are acknowledged by writing the request register. A 0 in a bit position clears that bit and a 1 keeps it.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After reset every block register reads 0xFFFF, every mode and polarity register reads 0x0000, no edge request is latched, and `cpu_irq`, `grp_pend` and `vec_valid` are all 0.
- R2: A block bit of 1 keeps its source out of `grp_pend`, `cpu_irq` and the vector, while the request register still shows the raw request. A block bit of 0 lets the source through.
- R3: With mode bit 0 (level), the request bit follows the input after polarity correction. With polarity 1 a high input requests and with polarity 0 a low input requests. The request falls when the input becomes inactive.
- R4: With mode bit 1 and polarity 1, a rising input edge sets the request bit. The bit stays set after the input returns low.
- R5: With mode bit 1 and polarity 0, a falling input edge sets the request bit, and a rising edge does not.
- R6: A write to a group's request register ANDs the latched edge requests with the written data. Writing 0 clears them and writing 1 keeps them. Level-mode bits are not changed by the write.
- R7: `grp_pend[g]` is 1 exactly when group g has a request bit set whose block bit is 0. Bit 0 is local bus, bit 1 is LPC, bit 2 is PCI and bit 3 is NMI. `cpu_irq` is the OR of the four bits.
- R8: The vector names a group in this priority order: group 3 first, then group 2, then group 0, then group 1.
- R9: Within the chosen group, the vector names the lowest-numbered unblocked pending bit.
- R10: `vec` = {group[1:0], index[3:0]}. `vec_valid` is 1 exactly when something is pending, and `vec` is 0 when nothing is pending.
- R11: The register address is {kind[2:0], group[1:0]}. Kind 0 is the block register, 1 the mode register, 2 the polarity register and 3 the request register. Kind 4 reads the summary in bits 3:0, whatever the group field holds. Writes to kind 4 and above are ignored.
- R12: An input change is reflected in the request bits, summary and vector one clock edge after it is applied. A register write takes effect on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 64 | Raw inputs; group g uses bits 16g+15 down to 16g |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address {kind, group} |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| grp_pend | output | 4 | Per-group pending summary |
| cpu_irq | output | 1 | Combined interrupt line to the processor |
| vec_valid | output | 1 | A source is pending |
| vec | output | 6 | Group and index of the source to serve |

## Verification
Request bits are registered. An input applied before a clock edge is therefore visible on `grp_pend`, `cpu_irq`, `vec` and the request readback just after that single edge. The bench drives inputs half a period away from the edge, advances exactly one edge and samples there. Block-register changes act through combinational logic on registered state, so they are checked one edge after the write. A change to the polarity or mode register needs one more edge before the request bit follows. The bench waits two edges after such writes before it samples.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_GRP = 4;
    localparam int GRP_IDW = $clog2(NUM_GRP);

    typedef enum logic [GRP_IDW-1:0] {
        GRP_LBUS = 2'd0,
        GRP_LPC  = 2'd1,
        GRP_PCI  = 2'd2,
        GRP_NMI  = 2'd3
    } grp_id_t;

    typedef enum logic [2:0] {
        KIND_BLOCK   = 3'd0,
        KIND_MODE    = 3'd1,
        KIND_POL     = 3'd2,
        KIND_REQ     = 3'd3,
        KIND_SUMMARY = 3'd4
    } reg_kind_t;

    // rank 0 is served first
    function automatic grp_id_t grp_at_rank(input int rank);
        case (rank)
            0:       return GRP_NMI;
            1:       return GRP_PCI;
            2:       return GRP_LBUS;
            default: return GRP_LPC;
        endcase
    endfunction

endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] src,
    input  logic          wr_block,
    input  logic          wr_mode,
    input  logic          wr_pol,
    input  logic          wr_req,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] block_q,
    output logic [GW-1:0] mode_q,
    output logic [GW-1:0] pol_q,
    output logic [GW-1:0] req_q,
    output logic [GW-1:0] live
);

    logic [GW-1:0] prev_q;
    logic [GW-1:0] active_now;
    logic [GW-1:0] active_prev;
    logic [GW-1:0] edge_hit;
    logic [GW-1:0] keep;
    logic [GW-1:0] req_d;

    always_comb begin
        active_now  = ~(src ^ pol_q);
        active_prev = ~(prev_q ^ pol_q);
        edge_hit    = active_now & ~active_prev;
        keep        = wr_req ? wdata : {GW{1'b1}};
        req_d       = (mode_q & (edge_hit | (req_q & keep)))
                    | (~mode_q & active_now);
        live        = req_q & ~block_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q <= {GW{1'b1}};
            mode_q  <= '0;
            pol_q   <= '0;
            req_q   <= '0;
            prev_q  <= '0;
        end else begin
            if (wr_block) block_q <= wdata;
            if (wr_mode)  mode_q  <= wdata;
            if (wr_pol)   pol_q   <= wdata;
            req_q  <= req_d;
            prev_q <= src;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import intc_pkg::*;
#(
    parameter int GW  = 16,
    parameter int IDW = $clog2(GW)
) (
    input  logic [NUM_GRP-1:0][GW-1:0] live,
    output logic [NUM_GRP-1:0]         grp_pend,
    output logic                       vec_valid,
    output logic [GRP_IDW+IDW-1:0]     vec
);

    grp_id_t        win_grp;
    logic [IDW-1:0] win_idx;
    logic [GW-1:0]  win_bits;

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_pend[g] = |live[g];
        end
        vec_valid = |grp_pend;

        win_grp = GRP_LBUS;
        for (int r = NUM_GRP - 1; r >= 0; r--) begin
            if (grp_pend[grp_at_rank(r)]) win_grp = grp_at_rank(r);
        end

        win_bits = live[win_grp];
        win_idx  = '0;
        for (int b = GW - 1; b >= 0; b--) begin
            if (win_bits[b]) win_idx = IDW'(b);
        end

        vec = vec_valid ? {win_grp, win_idx} : '0;
    end

endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
    import intc_pkg::*;
#(
    parameter int GW  = 16,
    parameter int IDW = $clog2(GW),
    parameter int AW  = 3 + GRP_IDW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_GRP*GW-1:0]       src,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [GW-1:0]               wdata,
    output logic [GW-1:0]               rdata,
    output logic [NUM_GRP-1:0]          grp_pend,
    output logic                        cpu_irq,
    output logic                        vec_valid,
    output logic [GRP_IDW+IDW-1:0]      vec
);

    reg_kind_t                 kind;
    logic [GRP_IDW-1:0]        gsel;
    logic [NUM_GRP-1:0][GW-1:0] block_q, mode_q, pol_q, req_q, live;

    assign kind = reg_kind_t'(addr[AW-1:GRP_IDW]);
    assign gsel = addr[GRP_IDW-1:0];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (gsel == GRP_IDW'(g));
        irq_group #(.GW(GW)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .src      (src[g*GW +: GW]),
            .wr_block (hit && kind == KIND_BLOCK),
            .wr_mode  (hit && kind == KIND_MODE),
            .wr_pol   (hit && kind == KIND_POL),
            .wr_req   (hit && kind == KIND_REQ),
            .wdata    (wdata),
            .block_q  (block_q[g]),
            .mode_q   (mode_q[g]),
            .pol_q    (pol_q[g]),
            .req_q    (req_q[g]),
            .live     (live[g])
        );
    end

    irq_arbiter #(.GW(GW), .IDW(IDW)) u_arb (
        .live      (live),
        .grp_pend  (grp_pend),
        .vec_valid (vec_valid),
        .vec       (vec)
    );

    assign cpu_irq = |grp_pend;

    always_comb begin
        case (kind)
            KIND_BLOCK:   rdata = block_q[gsel];
            KIND_MODE:    rdata = mode_q[gsel];
            KIND_POL:     rdata = pol_q[gsel];
            KIND_REQ:     rdata = req_q[gsel];
            KIND_SUMMARY: rdata = GW'(grp_pend);
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int VW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    grp_pend,
    input logic          cpu_irq,
    input logic          vec_valid,
    input logic [VW-1:0] vec
);

    // R7
    assert_line_or_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (|grp_pend));

    // R10
    assert_valid_R10: assert property (@(posedge clk) disable iff (rst)
        vec_valid == cpu_irq);

    // R10
    assert_idle_vec_R10: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> vec == '0);

    // R8
    assert_nmi_first_R8: assert property (@(posedge clk) disable iff (rst)
        grp_pend[3] |-> vec[VW-1:VW-2] == 2'd3);

    // R8
    assert_pci_over_lbus_R8: assert property (@(posedge clk) disable iff (rst)
        (grp_pend[2] && !grp_pend[3]) |-> vec[VW-1:VW-2] == 2'd2);

    // R9
    assert_grp_pending_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> grp_pend[vec[VW-1:VW-2]]);

endmodule

bind grouped_irq_ctrl intc_checker #(.VW(GRP_IDW + IDW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .grp_pend  (grp_pend),
    .cpu_irq   (cpu_irq),
    .vec_valid (vec_valid),
    .vec       (vec)
);

// File: tb/tb_grouped_irq_ctrl.sv
`timescale 1ns/1ps
module tb_grouped_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src;
    logic        wr_en;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [3:0]  grp_pend;
    logic        cpu_irq;
    logic        vec_valid;
    logic [5:0]  vec;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    grouped_irq_ctrl dut (
        .clk(clk), .rst(rst), .src(src), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .grp_pend(grp_pend), .cpu_irq(cpu_irq),
        .vec_valid(vec_valid), .vec(vec)
    );

    // {src[63:0], pend[3:0], valid, vec[5:0]}
    localparam int NV = 7;
    localparam logic [74:0] VECS [NV] = '{
        {64'h0,                    4'b0000, 1'b0, 6'h00},
        {64'h0000_0000_0000_0020,  4'b0001, 1'b1, 6'h05},
        {64'h0000_0000_0008_0200,  4'b0011, 1'b1, 6'h09},
        {64'h0000_0080_0000_0001,  4'b0101, 1'b1, 6'h27},
        {64'h8000_0001_0000_0000,  4'b1100, 1'b1, 6'h3F},
        {64'h0000_0000_1010_0000,  4'b0010, 1'b1, 6'h14},
        {64'h0000_8100_0000_0000,  4'b0100, 1'b1, 6'h28}
    };

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] kind, input logic [1:0] g, input logic [15:0] d);
        addr  = {kind, g};
        wdata = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] kind, input logic [1:0] g, output logic [15:0] d);
        addr = {kind, g};
        #1;
        d = rdata;
    endtask

    initial begin
        #150000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] r;
        rst = 1'b1; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        #2;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        for (int g = 0; g < 4; g++) begin
            rd(3'd0, 2'(g), r); chk("R1 block", 64'(r), 64'hFFFF);
            rd(3'd1, 2'(g), r); chk("R1 mode",  64'(r), 64'h0);
            rd(3'd2, 2'(g), r); chk("R1 pol",   64'(r), 64'h0);
        end
        chk("R1 cpu_irq", 64'(cpu_irq), 64'h0);
        chk("R1 vec_valid", 64'(vec_valid), 64'h0);
        // R3 active-low level with low inputs requests, R2 blocked
        rd(3'd3, 2'd0, r); chk("R3 active-low req", 64'(r), 64'hFFFF);
        chk("R2 blocked pend", 64'(grp_pend), 64'h0);

        // configure: active-high level, all unblocked
        for (int g = 0; g < 4; g++) begin
            wr(3'd2, 2'(g), 16'hFFFF);
            wr(3'd0, 2'(g), 16'h0000);
        end
        tick();

        // table walk: R7 R8 R9 R10 R12 (one edge after input)
        for (int i = 0; i < NV; i++) begin
            src = VECS[i][74:11];
            tick();
            chk("R7 grp_pend", 64'(grp_pend), 64'(VECS[i][10:7]));
            chk("R7 cpu_irq", 64'(cpu_irq), 64'(|VECS[i][10:7]));
            chk("R10 vec_valid", 64'(vec_valid), 64'(VECS[i][6]));
            chk("R8 R9 vec", 64'(vec), 64'(VECS[i][5:0]));
        end

        // R2 blocking one source
        src = 64'h20;
        wr(3'd0, 2'd0, 16'h0020);
        chk("R2 blocked pend", 64'(grp_pend), 64'h0);
        chk("R2 blocked irq", 64'(cpu_irq), 64'h0);
        rd(3'd3, 2'd0, r); chk("R2 raw req visible", 64'(r), 64'h0020);
        wr(3'd0, 2'd0, 16'h0000);
        chk("R2 unblocked pend", 64'(grp_pend), 64'h1);

        // R3 level follows input, active-low bit 0 of group 2
        src = '0;
        wr(3'd2, 2'd2, 16'hFFFE);
        tick();
        chk("R3 active-low pend", 64'(grp_pend), 64'h4);
        chk("R3 active-low vec", 64'(vec), 64'h20);
        src = 64'h0000_0001_0000_0000;
        tick();
        chk("R3 level falls", 64'(grp_pend), 64'h0);
        src = '0;
        wr(3'd2, 2'd2, 16'hFFFF);
        tick();

        // R4 rising edge latch on group 1 bit 2
        wr(3'd1, 2'd1, 16'h0004);
        src = 64'h0000_0000_0004_0000;
        tick();
        src = '0;
        tick();
        chk("R4 edge held pend", 64'(grp_pend), 64'h2);
        chk("R4 edge held vec", 64'(vec), 64'h12);

        // R6 write 1 keeps, write 0 clears
        wr(3'd3, 2'd1, 16'h0004);
        rd(3'd3, 2'd1, r); chk("R6 keep", 64'(r), 64'h0004);
        wr(3'd3, 2'd1, 16'h0000);
        rd(3'd3, 2'd1, r); chk("R6 clear", 64'(r), 64'h0);
        chk("R6 clear pend", 64'(grp_pend), 64'h0);

        // R5 falling edge on group 2 bit 6 (active-low)
        src = 64'h0000_0040_0000_0000;
        wr(3'd2, 2'd2, 16'hFFBF);
        wr(3'd1, 2'd2, 16'h0040);
        tick();
        chk("R5 idle before edge", 64'(grp_pend), 64'h0);
        src = '0;
        tick();
        src = 64'h0000_0040_0000_0000;
        tick();
        chk("R5 falling edge pend", 64'(grp_pend), 64'h4);
        chk("R5 falling edge vec", 64'(vec), 64'h26);

        // R11 summary read, group field ignored
        rd(3'd4, 2'd3, r); chk("R11 summary", 64'(r), 64'h4);
        wr(3'd5, 2'd2, 16'h0000);
        rd(3'd0, 2'd2, r); chk("R11 ignored write", 64'(r), 64'h0);
        wr(3'd3, 2'd2, 16'h0000);
        tick();
        chk("R5 rising ignored", 64'(grp_pend), 64'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule